// File: doc/BRIEF.md
# Virtual Address Translator with Buffered Page-Table Walk

This block turns 32-bit virtual addresses into physical addresses for 4 KB pages. A small fully associative translation buffer keyed by virtual page number answers most requests straight away. On a miss, the block reads a two-level page table through a word-wide memory port and installs the leaf entry. It then finishes the request as a buffer hit.

Each successful access marks the page as referenced, and each write access marks it as dirty. These marks are kept in the buffered entry. Whenever the stored table entry lacks a mark that the access demands, the updated entry is also written back to memory. A missing page at either table level ends the request with a fault response that carries the virtual address. The client sends one request at a time. It uses a valid/ready request handshake and receives a one-cycle response pulse.

Top module: `addr_xlate`

## Requirements
- R1: A successful response carries the frame number from bits 31:12 of the leaf table entry in rspAddr[31:12], and the request's virtual bits 11:0 unchanged in rspAddr[11:0].
- R2: A walk first reads the word at ptBase + 4*vaddr[31:22]. It then reads the word at {first word[31:12], vaddr[21:12], 2'b00}. A memory request and its address stay steady until memAck.
- R3: A table entry has its valid flag in bit 0, its referenced flag in bit 1, its dirty flag in bit 2 and its frame number in 31:12. If either walk read returns valid = 0, the response has rspFault = 1 and rspAddr equal to the virtual address.
- R4: The buffer holds 8 entries, searched by the 20-bit page number, and never has two matching entries. A hit whose flags need no change makes no memory access, and its rspValid rises 2 cycles after the accepting clock edge.
- R5: A miss on a resident page makes exactly two memory reads and installs the entry. A later access to the same page hits.
- R6: Refills go into buffer slots in round-robin order. With all 8 slots full, a ninth page replaces the one installed earliest, and the other seven keep hitting.
- R7: A successful access leaves the page's table word equal to {frame, 9'b0, dirty, 1, 1}, where dirty is set by any write and never cleared by a read. Exactly one memory write is made when the stored word lacked a needed flag, and none otherwise.
- R8: A one-cycle flush pulse empties the whole buffer, so the next access to any page walks the table again.
- R9: A fault installs nothing, so a repeated faulting access walks again. reqReady is high only while idle, and rspValid lasts exactly one cycle per request.
- R10: During and straight after reset, reqReady = 1, rspValid = 0, memRd = 0, memWr = 0, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the translation buffer |
| ptBase | input | 32 | Physical address of the first-level table |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and accepting |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 for a write access, 0 for a read |
| rspValid | output | 1 | One-cycle response strobe |
| rspFault | output | 1 | Response is a page fault |
| rspAddr | output | 32 | Physical address, or the faulting virtual address |
| memRd | output | 1 | Table word read request |
| memWr | output | 1 | Table word write request |
| memAddr | output | 32 | Byte address of the table word |
| memWdata | output | 32 | Updated table entry for write-back |
| memAck | input | 1 | Memory done; memRdata valid for reads |
| memRdata | input | 32 | Table word read from memory |

## Verification
Some properties are checked on every cycle. The buffer never holds two matching entries. A flush empties it at the next edge. A freshly installed entry matches at once. Memory requests hold their address until acknowledged, and responses are single-cycle. A successful response keeps the page offset, and a fault returns the request address.

Other behaviour shows only in the bench's scenarios, which compare against a model of the table memory and an 8-slot round-robin buffer. These cover the exact frame returned, the number of reads and write-backs per request, the write-back word with its flags, the eviction order, whether faults leave the buffer alone, and the two-cycle hit latency.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_RD1,
    ST_RD2,
    ST_WB,
    ST_RESP
  } xlState_e;

  typedef enum logic [1:0] {
    SEL_L1,
    SEL_L2,
    SEL_WB
  } memSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    latchReq;
    logic    latchHit;
    logic    touch;
    logic    saveL1;
    logic    install;
    logic    setFault;
    memSel_e memSel;
  } xlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic hit;
    logic needTouch;
  } xlStatus_t;

endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      rspValid,
  output logic      memRd,
  output logic      memWr,
  input  logic      memAck,
  input  logic      pteValid,
  input  xlStatus_t stat,
  output xlStrobe_t strobe
);

  xlState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe        = '0;
    strobe.memSel = SEL_L1;
    nextState     = state;
    reqReady      = (state == ST_IDLE);
    rspValid      = (state == ST_RESP);
    memRd         = (state == ST_RD1) || (state == ST_RD2);
    memWr         = (state == ST_WB);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          nextState       = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (stat.hit) begin
          strobe.latchHit = 1'b1;
          if (stat.needTouch) begin
            strobe.touch = 1'b1;
            nextState    = ST_WB;
          end else begin
            nextState = ST_RESP;
          end
        end else begin
          nextState = ST_RD1;
        end
      end
      ST_RD1: begin
        strobe.memSel = SEL_L1;
        if (memAck) begin
          if (pteValid) begin
            strobe.saveL1 = 1'b1;
            nextState     = ST_RD2;
          end else begin
            strobe.setFault = 1'b1;
            nextState       = ST_RESP;
          end
        end
      end
      ST_RD2: begin
        strobe.memSel = SEL_L2;
        if (memAck) begin
          if (pteValid) begin
            strobe.install = 1'b1;
            nextState      = ST_LOOK;
          end else begin
            strobe.setFault = 1'b1;
            nextState       = ST_RESP;
          end
        end
      end
      ST_WB: begin
        strobe.memSel = SEL_WB;
        if (memAck) nextState = ST_RESP;
      end
      ST_RESP:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/xlate_path.sv
module xlate_path
  import xlate_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int TLB_DEPTH = 8,
  localparam int ADDR_W   = 3 * PAGE_BITS - 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic [ADDR_W-1:0] ptBase,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] memRdata,
  input  xlStrobe_t         strobe,
  output xlStatus_t         stat,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspFault
);

  localparam int IDX_BITS = PAGE_BITS - 2;
  localparam int VPN_W    = ADDR_W - PAGE_BITS;
  localparam int PTR_W    = (TLB_DEPTH > 1) ? $clog2(TLB_DEPTH) : 1;

  logic [ADDR_W-1:0] vaddrQ;
  logic              writeQ;
  logic [VPN_W-1:0]  l1FrameQ;
  logic [ADDR_W-1:0] wbAddrQ, wbDataQ;
  logic [PTR_W-1:0]  rrPtr;

  logic [TLB_DEPTH-1:0] entValid, entRef, entDirty;
  logic [VPN_W-1:0]     entVpn [TLB_DEPTH];
  logic [VPN_W-1:0]     entPfn [TLB_DEPTH];
  logic [ADDR_W-1:0]    entPte [TLB_DEPTH];

  logic [VPN_W-1:0]     vpn;
  logic [IDX_BITS-1:0]  vpnHi, vpnLo;
  logic [TLB_DEPTH-1:0] matchVec;
  logic [VPN_W-1:0]     hitPfn;
  logic [ADDR_W-1:0]    hitPte;
  logic                 hitRef, hitDirty;
  logic [ADDR_W-1:0]    l1Addr, l2Addr;
  logic                 unusedPteBits;

  assign vpn   = vaddrQ[ADDR_W-1:PAGE_BITS];
  assign vpnHi = vaddrQ[ADDR_W-1 -: IDX_BITS];
  assign vpnLo = vaddrQ[PAGE_BITS +: IDX_BITS];
  assign unusedPteBits = ^memRdata[PAGE_BITS-1:3];

  // content-addressed search
  for (genvar g = 0; g < TLB_DEPTH; g++) begin : gMatch
    assign matchVec[g] = entValid[g] && (entVpn[g] == vpn);
  end

  always_comb begin
    hitPfn   = '0;
    hitPte   = '0;
    hitRef   = 1'b0;
    hitDirty = 1'b0;
    for (int i = 0; i < TLB_DEPTH; i++) begin
      hitPfn   = hitPfn | (entPfn[i] & {VPN_W{matchVec[i]}});
      hitPte   = hitPte | (entPte[i] & {ADDR_W{matchVec[i]}});
      hitRef   = hitRef | (entRef[i] & matchVec[i]);
      hitDirty = hitDirty | (entDirty[i] & matchVec[i]);
    end
  end

  assign stat.hit       = |matchVec;
  assign stat.needTouch = !hitRef || (writeQ && !hitDirty);

  // walk addresses
  assign l1Addr = ptBase + ADDR_W'({vpnHi, 2'b00});
  assign l2Addr = {l1FrameQ, vpnLo, 2'b00};

  always_comb begin
    case (strobe.memSel)
      SEL_L2:  memAddr = l2Addr;
      SEL_WB:  memAddr = wbAddrQ;
      default: memAddr = l1Addr;
    endcase
  end
  assign memWdata = wbDataQ;

  // request, walk and response registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ   <= '0;
      writeQ   <= 1'b0;
      l1FrameQ <= '0;
      wbAddrQ  <= '0;
      wbDataQ  <= '0;
      rspAddr  <= '0;
      rspFault <= 1'b0;
    end else begin
      if (strobe.latchReq) begin
        vaddrQ   <= reqVaddr;
        writeQ   <= reqWrite;
        rspFault <= 1'b0;
      end
      if (strobe.saveL1) l1FrameQ <= memRdata[ADDR_W-1:PAGE_BITS];
      if (strobe.latchHit) begin
        wbAddrQ  <= hitPte;
        wbDataQ  <= {hitPfn, {(PAGE_BITS-3){1'b0}}, hitDirty | writeQ, 1'b1, 1'b1};
        rspAddr  <= {hitPfn, vaddrQ[PAGE_BITS-1:0]};
        rspFault <= 1'b0;
      end
      if (strobe.setFault) begin
        rspAddr  <= vaddrQ;
        rspFault <= 1'b1;
      end
    end
  end

  // buffer flags and replacement pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      entRef   <= '0;
      entDirty <= '0;
      rrPtr    <= '0;
    end else begin
      if (flush) entValid <= '0;
      for (int i = 0; i < TLB_DEPTH; i++) begin
        if (strobe.touch && matchVec[i]) begin
          entRef[i]   <= 1'b1;
          entDirty[i] <= entDirty[i] | writeQ;
        end
      end
      if (strobe.install) begin
        entValid[rrPtr] <= 1'b1;
        entRef[rrPtr]   <= memRdata[1];
        entDirty[rrPtr] <= memRdata[2];
        rrPtr <= (rrPtr == PTR_W'(TLB_DEPTH - 1)) ? '0 : rrPtr + 1'b1;
      end
    end
  end

  // buffer payload
  always_ff @(posedge clk) begin
    if (strobe.install) begin
      entVpn[rrPtr] <= vpn;
      entPfn[rrPtr] <= memRdata[ADDR_W-1:PAGE_BITS];
      entPte[rrPtr] <= l2Addr;
    end
  end

  // R4
  tlb_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flush && !strobe.install) |=> (entValid == '0));

  // R5
  install_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.install |=> stat.hit);

endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import xlate_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int TLB_DEPTH = 8,
  localparam int ADDR_W   = 3 * PAGE_BITS - 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic [ADDR_W-1:0] ptBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  output logic              rspValid,
  output logic              rspFault,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [ADDR_W-1:0] memRdata
);

  xlStrobe_t strobe;
  xlStatus_t stat;

  xlate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .memRd    (memRd),
    .memWr    (memWr),
    .memAck   (memAck),
    .pteValid (memRdata[0]),
    .stat     (stat),
    .strobe   (strobe)
  );

  xlate_path #(
    .PAGE_BITS (PAGE_BITS),
    .TLB_DEPTH (TLB_DEPTH)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .ptBase   (ptBase),
    .reqVaddr (reqVaddr),
    .reqWrite (reqWrite),
    .memRdata (memRdata),
    .strobe   (strobe),
    .stat     (stat),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .rspAddr  (rspAddr),
    .rspFault (rspFault)
  );

  // request address seen at acceptance, kept for the response checks
  logic [ADDR_W-1:0] acceptedVa;
  always_ff @(posedge clk) begin
    if (!rstN)                     acceptedVa <= '0;
    else if (reqValid && reqReady) acceptedVa <= reqVaddr;
  end

  // R1
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> (rspAddr[PAGE_BITS-1:0] == acceptedVa[PAGE_BITS-1:0]));

  // R3
  fault_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspAddr == acceptedVa));

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((memRd || memWr) && !memAck) |=> ((memRd || memWr) && $stable(memAddr)));

endmodule

// File: tb/addr_xlate_test.sv
module addr_xlate_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] ptBase = 32'h0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqVaddr = 32'h0;
  logic        reqReady, rspValid, rspFault, memRd, memWr;
  logic [31:0] rspAddr, memAddr, memWdata;
  logic        memAck;
  logic [31:0] memRdata;

  always #2 clk = ~clk;

  addr_xlate uut (
    .clk(clk), .rstN(rstN), .flush(flush), .ptBase(ptBase),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .rspValid(rspValid), .rspFault(rspFault), .rspAddr(rspAddr),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  // table memory: first level at 0, second-level tables at 0x1000, 0x2000, 0x3000
  logic [31:0] mem [0:4095];
  int          rdCount = 0;
  int          wrCount = 0;
  logic [31:0] rdHist [0:3];

  always @(posedge clk) begin
    if (!rstN) begin
      memAck   <= 1'b0;
      memRdata <= 32'h0;
    end else if ((memRd || memWr) && !memAck) begin
      memAck <= 1'b1;
      if (memRd) begin
        memRdata <= mem[memAddr[13:2]];
        rdHist[rdCount % 4] <= memAddr;
        rdCount <= rdCount + 1;
      end else begin
        mem[memAddr[13:2]] <= memWdata;
        wrCount <= wrCount + 1;
      end
    end else begin
      memAck <= 1'b0;
    end
  end

  int nChecks = 0;
  int nFail   = 0;

  // model state
  logic [4095:0] shRef, shDirty;
  int            mVpn [8];
  bit            mVal [8];
  int            mRr = 0;
  int            lastReads;

  function automatic int tblOf(input int hi);
    if (hi == 0)    return 1;
    if (hi == 3)    return 2;
    if (hi == 1023) return 3;
    return 0;
  endfunction

  function automatic logic [19:0] pfnOf(input int t, input int j);
    int v;
    v = 32'h80000 + t * 1024 + j * 13;
    return v[19:0];
  endfunction

  function automatic bit leafOk(input int j);
    return (j % 5) != 4;
  endfunction

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!cond) begin
      nFail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int k = 0; k < 8; k++) mVal[k] = 1'b0;
  endtask

  task automatic access(input int hi, input int lo, input int off, input bit wr);
    logic [31:0] va, expAddr, expWord;
    int t, word, vpn, hitK, expR, expW, r0, w0, lat;
    bit ok, needT;
    va   = {hi[9:0], lo[9:0], off[11:0]};
    t    = tblOf(hi);
    word = t * 1024 + lo;
    vpn  = hi * 1024 + lo;
    hitK = -1;
    for (int k = 0; k < 8; k++) if (mVal[k] && mVpn[k] == vpn) hitK = k;
    needT = 1'b0;
    if (hitK >= 0) begin
      expR = 0; ok = 1'b1;
    end else if (t == 0) begin
      expR = 1; ok = 1'b0;
    end else if (!leafOk(lo)) begin
      expR = 2; ok = 1'b0;
    end else begin
      expR = 2; ok = 1'b1;
      mVpn[mRr] = vpn; mVal[mRr] = 1'b1; mRr = (mRr + 1) % 8;
    end
    expW = 0;
    if (ok) begin
      needT = !shRef[word] || (wr && !shDirty[word]);
      expW  = needT ? 1 : 0;
      shRef[word] = 1'b1;
      if (wr) shDirty[word] = 1'b1;
    end
    expAddr = ok ? {pfnOf(t, lo), off[11:0]} : va;

    @(negedge clk);
    reqVaddr = va; reqWrite = wr; reqValid = 1'b1;
    r0 = rdCount; w0 = wrCount;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspValid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    lastReads = rdCount - r0;
    chk(rspValid, "R9 response arrives", 32'(rspValid), 32'h1);
    chk(reqReady == 1'b0, "R9 not ready while responding", 32'(reqReady), 32'h0);
    chk(rspFault == !ok, "R3 fault flag", 32'(rspFault), 32'(!ok));
    chk(rspAddr == expAddr, ok ? "R1 physical address" : "R3 fault address", rspAddr, expAddr);
    chk(lastReads == expR, (hitK >= 0) ? "R4 no reads on hit" : "R5 walk read count", 32'(lastReads), 32'(expR));
    chk((wrCount - w0) == expW, "R7 write-back count", 32'(wrCount - w0), 32'(expW));
    if (expR >= 1)
      chk(rdHist[r0 % 4] == ptBase + hi * 4, "R2 first-level address", rdHist[r0 % 4], ptBase + hi * 4);
    if (expR == 2)
      chk(rdHist[(r0 + 1) % 4] == {t[19:0], lo[9:0], 2'b00}, "R2 second-level address",
          rdHist[(r0 + 1) % 4], {t[19:0], lo[9:0], 2'b00});
    if (ok) begin
      expWord = {pfnOf(t, lo), 9'b0, shDirty[word], 1'b1, 1'b1};
      chk(mem[word] == expWord, "R7 table word flags", mem[word], expWord);
    end
    if (hitK >= 0 && !needT)
      chk(lat == 2, "R4 hit latency", 32'(lat), 32'h2);
    @(negedge clk);
    chk(!rspValid, "R9 one-cycle response", 32'(rspValid), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    mem[0]    = 32'h0000_1001;
    mem[3]    = 32'h0000_2001;
    mem[1023] = 32'h0000_3001;
    shRef = '0; shDirty = '0;
    for (int t = 1; t <= 3; t++) begin
      for (int j = 0; j < 1024; j++) begin
        shRef[t * 1024 + j]   = (j % 3) == 0;
        shDirty[t * 1024 + j] = (j % 6) == 0;
        if (leafOk(j))
          mem[t * 1024 + j] = {pfnOf(t, j), 9'b0, shDirty[t * 1024 + j], shRef[t * 1024 + j], 1'b1};
        else
          mem[t * 1024 + j] = {pfnOf(t, j), 12'b0};
      end
    end
    for (int k = 0; k < 8; k++) begin mVal[k] = 1'b0; mVpn[k] = 0; end

    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(reqReady == 1'b1, "R10 reqReady in reset", 32'(reqReady), 32'h1);
    chk(rspValid == 1'b0, "R10 rspValid in reset", 32'(rspValid), 32'h0);
    chk(!memRd && !memWr, "R10 memory idle in reset", {30'b0, memRd, memWr}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R10 reqReady after reset", 32'(reqReady), 32'h1);

    // sweep over three second-level tables, reads and writes
    for (int p = 0; p < 2; p++) begin
      for (int h = 0; h < 3; h++) begin
        for (int lo = 0; lo < 24; lo++) begin
          access((h == 0) ? 0 : ((h == 1) ? 3 : 1023), lo, (lo * 37 + h * 501 + p * 7) & 12'hfff, (lo + p) % 2);
        end
      end
    end

    // hit sweep: a block of 8 pages, each revisited with different offsets
    doFlush();
    for (int r = 0; r < 4; r++)
      for (int lo = 100; lo < 110; lo++)
        if (leafOk(lo)) access(3, lo, (r * 1111 + lo) & 12'hfff, r == 2);

    // R6 eviction order
    doFlush();
    access(0, 0, 12'h010, 1'b0);
    access(0, 1, 12'h020, 1'b0);
    access(0, 2, 12'h030, 1'b0);
    access(0, 3, 12'h040, 1'b0);
    access(0, 5, 12'h050, 1'b0);
    access(0, 6, 12'h060, 1'b0);
    access(0, 7, 12'h070, 1'b0);
    access(0, 8, 12'h080, 1'b0);
    access(0, 0, 12'h011, 1'b0);
    chk(lastReads == 0, "R6 all eight slots held", 32'(lastReads), 32'h0);
    access(3, 0, 12'h090, 1'b0);
    access(0, 1, 12'h021, 1'b0);
    chk(lastReads == 0, "R6 second-oldest kept", 32'(lastReads), 32'h0);
    access(0, 0, 12'h012, 1'b0);
    chk(lastReads == 2, "R6 oldest evicted", 32'(lastReads), 32'h2);

    // R9 faults are not cached
    access(1, 5, 12'h123, 1'b0);
    access(1, 5, 12'h124, 1'b1);
    chk(lastReads == 1, "R9 fault walks again", 32'(lastReads), 32'h1);
    access(500, 0, 12'hfff, 1'b1);
    access(3, 4, 12'h001, 1'b0);
    access(3, 4, 12'h002, 1'b0);
    chk(lastReads == 2, "R9 leaf fault walks again", 32'(lastReads), 32'h2);

    // R8 flush forces a new walk
    access(1023, 7, 12'h333, 1'b1);
    access(1023, 7, 12'h334, 1'b0);
    chk(lastReads == 0, "R8 cached before flush", 32'(lastReads), 32'h0);
    doFlush();
    access(1023, 7, 12'h335, 1'b0);
    chk(lastReads == 2, "R8 walk after flush", 32'(lastReads), 32'h2);

    // R7 write to an already dirty page makes no write-back
    access(1023, 7, 12'h336, 1'b1);
    access(1023, 7, 12'h337, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule